// File: doc/BRIEF.md
# 64b/66b Payload Scrambler and Descrambler Pair

This block holds both directions of the self-synchronizing scrambling used on 64b/66b links. Each direction takes one 64-bit payload word and its 2-bit sync header per clock. The payload is scrambled or descrambled with the polynomial 1 + x^39 + x^58. The header always passes through unscrambled. All 64 serial steps are flattened into one layer of XOR logic, and a 58-bit history register advances once per accepted word.

Each direction has a run-time enable that bypasses scrambling. A build-time parameter adds a bit-order reversal stage for serdes ports that count bits the other way. On transmit the reversal follows scrambling. On receive it comes before descrambling. Both outputs are registered, so a word accepted on one edge appears after that edge and stays until the next accepted word.

Top module: `scr66_duplex`

## Requirements
- R1: While reset is asserted, both output valids are low and both output payloads and headers are all zeros. Both history registers also return to zero.
- R2: Transmit scrambling handles payload bits in order from bit 0 to bit 63. Output bit i is input bit i XOR history bit 38 XOR history bit 57. After each bit, the history shifts up by one and the produced output bit enters bit 0. The history starts at zero.
- R3: Receive descrambling uses the same taps and the same bit order. The difference is that the received (scrambled) bit enters history bit 0.
- R4: With reversal off, the output header equals the input header of the same accepted word.
- R5: When a direction's scramble enable is low, an accepted payload passes unchanged (apart from reversal) and that direction's history holds its value. Later scrambled words continue from the held history.
- R6: A cycle with the valid input low drives that direction's output valid low on the next cycle. It leaves the output payload, the output header and the history unchanged.
- R7: An accepted word appears at the outputs, with output valid high, on the cycle after the edge that accepts it.
- R8: With reversal on, transmit reverses after scrambling: bit i moves to bit 63−i and the two header bits swap. Receive applies the same mapping to its input before descrambling.
- R9: When the transmit output feeds the receive input, the receive output equals the original transmit payload and header from the second chained word on. This holds whatever the receive history was before chaining began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Transmit word present |
| tx_scr_en | input | 1 | Transmit scrambling enable |
| tx_payload | input | 64 | Transmit payload before scrambling |
| tx_hdr | input | 2 | Transmit sync header |
| tx_out_valid | output | 1 | Transmit output word present |
| tx_out_payload | output | 64 | Scrambled (and optionally reversed) payload |
| tx_out_hdr | output | 2 | Header, optionally swapped |
| rx_valid | input | 1 | Receive word present |
| rx_scr_en | input | 1 | Receive descrambling enable |
| rx_payload | input | 64 | Received scrambled payload |
| rx_hdr | input | 2 | Received sync header |
| rx_out_valid | output | 1 | Receive output word present |
| rx_out_payload | output | 64 | Descrambled payload |
| rx_out_hdr | output | 2 | Header, optionally swapped |

## Verification
The bench builds the block twice with the default widths and taps (64-bit payload, 58-bit history, taps at delays 39 and 58). One copy has REVERSE at 0 and the other has it at 1. Both copies get the same transmit stimulus, so the plain and mirrored bit orders, including the header swap and the receive-side reversal ahead of descrambling, are compared word by word against a serial reference model. The chained run feeds each copy's transmit output back into its own receive input while its receive history holds unrelated earlier traffic. This shows that each copy resynchronizes within one word.

// File: rtl/scr66_duplex.sv
module scr66_duplex #(
  parameter int DATA_W   = 64,
  parameter int HDR_W    = 2,
  parameter int STATE_W  = 58,
  parameter int TAP_NEAR = 39,
  parameter int TAP_FAR  = 58,
  parameter bit REVERSE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic              tx_scr_en,
  input  logic [DATA_W-1:0] tx_payload,
  input  logic [HDR_W-1:0]  tx_hdr,
  output logic              tx_out_valid,
  output logic [DATA_W-1:0] tx_out_payload,
  output logic [HDR_W-1:0]  tx_out_hdr,
  input  logic              rx_valid,
  input  logic              rx_scr_en,
  input  logic [DATA_W-1:0] rx_payload,
  input  logic [HDR_W-1:0]  rx_hdr,
  output logic              rx_out_valid,
  output logic [DATA_W-1:0] rx_out_payload,
  output logic [HDR_W-1:0]  rx_out_hdr
);

  localparam int EXT_W = STATE_W + DATA_W;
  localparam int RES_W = STATE_W + DATA_W;

  // Flattened serial walk: ext holds the oldest history bit at index 0,
  // followed by the bits shifted in during this word.
  function automatic logic [RES_W-1:0] walk(input logic [STATE_W-1:0] st,
                                            input logic [DATA_W-1:0]  din,
                                            input logic               feed_out);
    logic [EXT_W-1:0]   ext;
    logic [DATA_W-1:0]  dout;
    logic [STATE_W-1:0] nst;
    ext = '0;
    for (int j = 0; j < STATE_W; j++) ext[j] = st[STATE_W-1-j];
    for (int i = 0; i < DATA_W; i++) begin
      dout[i] = din[i] ^ ext[STATE_W+i-TAP_NEAR] ^ ext[STATE_W+i-TAP_FAR];
      ext[STATE_W+i] = feed_out ? dout[i] : din[i];
    end
    for (int k = 0; k < STATE_W; k++) nst[k] = ext[EXT_W-1-k];
    return {nst, dout};
  endfunction

  function automatic logic [DATA_W-1:0] flip_data(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  function automatic logic [HDR_W-1:0] flip_hdr(input logic [HDR_W-1:0] v);
    logic [HDR_W-1:0] r;
    for (int i = 0; i < HDR_W; i++) r[i] = v[HDR_W-1-i];
    return r;
  endfunction

  logic [STATE_W-1:0] tx_state, rx_state;
  logic [RES_W-1:0]   tx_res, rx_res;
  logic [DATA_W-1:0]  tx_word, tx_word_o, rx_pre, rx_word;
  logic [HDR_W-1:0]   tx_hdr_o, rx_hdr_o;

  assign tx_res  = walk(tx_state, tx_payload, 1'b1);
  assign tx_word = tx_scr_en ? tx_res[DATA_W-1:0] : tx_payload;

  generate
    if (REVERSE) begin : g_rev
      assign tx_word_o = flip_data(tx_word);
      assign tx_hdr_o  = flip_hdr(tx_hdr);
      assign rx_pre    = flip_data(rx_payload);
      assign rx_hdr_o  = flip_hdr(rx_hdr);
    end else begin : g_fwd
      assign tx_word_o = tx_word;
      assign tx_hdr_o  = tx_hdr;
      assign rx_pre    = rx_payload;
      assign rx_hdr_o  = rx_hdr;
    end
  endgenerate

  assign rx_res  = walk(rx_state, rx_pre, 1'b0);
  assign rx_word = rx_scr_en ? rx_res[DATA_W-1:0] : rx_pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_state       <= '0;
      tx_out_valid   <= 1'b0;
      tx_out_payload <= '0;
      tx_out_hdr     <= '0;
    end else begin
      tx_out_valid <= tx_valid;
      if (tx_valid) begin
        tx_out_payload <= tx_word_o;
        tx_out_hdr     <= tx_hdr_o;
        if (tx_scr_en) tx_state <= tx_res[RES_W-1:DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_state       <= '0;
      rx_out_valid   <= 1'b0;
      rx_out_payload <= '0;
      rx_out_hdr     <= '0;
    end else begin
      rx_out_valid <= rx_valid;
      if (rx_valid) begin
        rx_out_payload <= rx_word;
        rx_out_hdr     <= rx_hdr_o;
        if (rx_scr_en) rx_state <= rx_res[RES_W-1:DATA_W];
      end
    end
  end

endmodule

// File: rtl/scr66_duplex_chk.sv
module scr66_duplex_chk #(
  parameter int DATA_W  = 64,
  parameter int HDR_W   = 2,
  parameter bit REVERSE = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_scr_en,
  input logic [DATA_W-1:0] tx_payload,
  input logic [HDR_W-1:0]  tx_hdr,
  input logic              tx_out_valid,
  input logic [DATA_W-1:0] tx_out_payload,
  input logic [HDR_W-1:0]  tx_out_hdr,
  input logic              rx_valid,
  input logic              rx_scr_en,
  input logic [DATA_W-1:0] rx_payload,
  input logic [HDR_W-1:0]  rx_hdr,
  input logic              rx_out_valid,
  input logic [DATA_W-1:0] rx_out_payload,
  input logic [HDR_W-1:0]  rx_out_hdr
);

  function automatic logic [DATA_W-1:0] map_d(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = REVERSE ? v[DATA_W-1-i] : v[i];
    return r;
  endfunction

  function automatic logic [HDR_W-1:0] map_h(input logic [HDR_W-1:0] v);
    logic [HDR_W-1:0] r;
    for (int i = 0; i < HDR_W; i++) r[i] = REVERSE ? v[HDR_W-1-i] : v[i];
    return r;
  endfunction

  // R7
  tx_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_out_valid);
  // R7
  rx_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_out_valid);
  // R6
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |=> (!tx_out_valid && $stable(tx_out_payload) && $stable(tx_out_hdr)));
  // R6
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (!rx_out_valid && $stable(rx_out_payload) && $stable(rx_out_hdr)));
  // R4
  tx_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> (tx_out_hdr == map_h($past(tx_hdr))));
  // R8
  rx_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (rx_out_hdr == map_h($past(rx_hdr))));
  // R5
  tx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_scr_en) |=> (tx_out_payload == map_d($past(tx_payload))));
  // R5
  rx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_scr_en) |=> (rx_out_payload == map_d($past(rx_payload))));

endmodule

bind scr66_duplex scr66_duplex_chk #(.DATA_W(DATA_W), .HDR_W(HDR_W), .REVERSE(REVERSE)) chk_i (.*);

// File: tb/scr66_duplex_tb_top.sv
module scr66_duplex_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        tx_v, tx_en, rx_v, rx_en;
  logic [63:0] tx_p, rx0_p, rx1_p;
  logic [1:0]  tx_h, rx0_h, rx1_h;
  logic        o0_txv, o0_rxv, o1_txv, o1_rxv;
  logic [63:0] o0_txp, o0_rxp, o1_txp, o1_rxp;
  logic [1:0]  o0_txh, o0_rxh, o1_txh, o1_rxh;

  int vectors = 0;
  int miscompares = 0;

  logic [57:0] m_tx, m_rx0, m_rx1;
  logic        e_txv, e_rxv;
  logic [63:0] e_tx0p, e_tx1p, e_rx0p, e_rx1p;
  logic [1:0]  e_tx0h, e_tx1h, e_rx0h, e_rx1h;

  scr66_duplex #(.REVERSE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_v), .tx_scr_en(tx_en), .tx_payload(tx_p), .tx_hdr(tx_h),
    .tx_out_valid(o0_txv), .tx_out_payload(o0_txp), .tx_out_hdr(o0_txh),
    .rx_valid(rx_v), .rx_scr_en(rx_en), .rx_payload(rx0_p), .rx_hdr(rx0_h),
    .rx_out_valid(o0_rxv), .rx_out_payload(o0_rxp), .rx_out_hdr(o0_rxh));

  scr66_duplex #(.REVERSE(1'b1)) dut_rev_i (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_v), .tx_scr_en(tx_en), .tx_payload(tx_p), .tx_hdr(tx_h),
    .tx_out_valid(o1_txv), .tx_out_payload(o1_txp), .tx_out_hdr(o1_txh),
    .rx_valid(rx_v), .rx_scr_en(rx_en), .rx_payload(rx1_p), .rx_hdr(rx1_h),
    .rx_out_valid(o1_rxv), .rx_out_payload(o1_rxp), .rx_out_hdr(o1_rxh));

  // Serial reference: bit 0 first, taps at history bits 38 and 57.
  function automatic logic [121:0] serial(input logic [57:0] st, input logic [63:0] d, input bit tx);
    logic [63:0] o;
    logic b;
    for (int i = 0; i < 64; i++) begin
      b = d[i] ^ st[38] ^ st[57];
      o[i] = b;
      st = {st[56:0], tx ? b : d[i]};
    end
    return {st, o};
  endfunction

  function automatic logic [63:0] rev64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[63-i];
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    logic [121:0] r;
    logic [63:0]  pre;
    if (tx_v) begin
      r = serial(m_tx, tx_p, 1'b1);
      e_tx0p = tx_en ? r[63:0] : tx_p;
      if (tx_en) m_tx = r[121:64];
      e_tx1p = rev64(e_tx0p);
      e_tx0h = tx_h;
      e_tx1h = {tx_h[0], tx_h[1]};
    end
    if (rx_v) begin
      r = serial(m_rx0, rx0_p, 1'b0);
      e_rx0p = rx_en ? r[63:0] : rx0_p;
      if (rx_en) m_rx0 = r[121:64];
      pre = rev64(rx1_p);
      r = serial(m_rx1, pre, 1'b0);
      e_rx1p = rx_en ? r[63:0] : pre;
      if (rx_en) m_rx1 = r[121:64];
      e_rx0h = rx0_h;
      e_rx1h = {rx1_h[0], rx1_h[1]};
    end
    e_txv = tx_v;
    e_rxv = rx_v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all();
    chk("R7", "tx valid", {63'b0, o0_txv}, {63'b0, e_txv});
    chk("R7", "rx valid", {63'b0, o0_rxv}, {63'b0, e_rxv});
    chk("R7", "tx valid rev", {63'b0, o1_txv}, {63'b0, e_txv});
    chk("R2", "tx payload", o0_txp, e_tx0p);
    chk("R3", "rx payload", o0_rxp, e_rx0p);
    chk("R4", "tx hdr", {62'b0, o0_txh}, {62'b0, e_tx0h});
    chk("R4", "rx hdr", {62'b0, o0_rxh}, {62'b0, e_rx0h});
    chk("R8", "tx payload rev", o1_txp, e_tx1p);
    chk("R8", "rx payload rev", o1_rxp, e_rx1p);
    chk("R8", "tx hdr rev", {62'b0, o1_txh}, {62'b0, e_tx1h});
    chk("R8", "rx hdr rev", {62'b0, o1_rxh}, {62'b0, e_rx1h});
  endtask

  task automatic put(input logic [63:0] t, input logic [1:0] th, input logic [63:0] r, input logic [1:0] rh);
    tx_v = 1'b1; rx_v = 1'b1;
    tx_p = t; tx_h = th;
    rx0_p = r; rx0_h = rh;
    rx1_p = ~r; rx1_h = ~rh;
  endtask

  task automatic t_reset();
    chk("R1", "tx valid in reset", {63'b0, o0_txv | o1_txv}, 64'd0);
    chk("R1", "rx valid in reset", {63'b0, o0_rxv | o1_rxv}, 64'd0);
    chk("R1", "tx payload in reset", o0_txp | o1_txp, 64'd0);
    chk("R1", "rx payload in reset", o0_rxp | o1_rxp, 64'd0);
    chk("R1", "hdrs in reset", {60'b0, o0_txh, o0_rxh}, 64'd0);
  endtask

  task automatic t_patterns();
    put(64'h0, 2'b10, 64'h0, 2'b10);                                   cyc(); check_all();
    put(64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 64'h5555_5555_5555_5555, 2'b01); cyc(); check_all();
    put(64'hAAAA_5555_AAAA_5555, 2'b10, 64'h0123_4567_89AB_CDEF, 2'b10); cyc(); check_all();
    for (int k = 0; k < 64; k += 9) begin
      put(64'd1 << k, 2'b10, ~(64'd1 << k), 2'b01); cyc(); check_all();
    end
    put(64'h0, 2'b10, 64'h0, 2'b10);                                   cyc(); check_all();
  endtask

  task automatic t_idle();
    logic [63:0] h0, h1;
    h0 = o0_txp; h1 = o0_rxp;
    for (int k = 0; k < 3; k++) begin
      tx_v = 1'b0; rx_v = 1'b0;
      tx_p = 64'hDEAD_BEEF_0000_0000 + 64'(k); rx0_p = ~tx_p; rx1_p = tx_p;
      tx_h = 2'b11; rx0_h = 2'b00; rx1_h = 2'b11;
      cyc();
      chk("R6", "tx valid low", {63'b0, o0_txv}, 64'd0);
      chk("R6", "tx payload held", o0_txp, h0);
      chk("R6", "rx payload held", o0_rxp, h1);
    end
    put(64'h1357_9BDF_0246_8ACE, 2'b01, 64'hFEDC_BA98_7654_3210, 2'b10); cyc(); check_all();
  endtask

  task automatic t_bypass();
    tx_en = 1'b0; rx_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      put(64'hC0FF_EE00_1234_0000 + 64'(k), 2'b10, 64'h7777_0000_BBBB_0000 + 64'(k), 2'b01);
      cyc();
      chk("R5", "tx bypass", o0_txp, 64'hC0FF_EE00_1234_0000 + 64'(k));
      chk("R5", "rx bypass", o0_rxp, 64'h7777_0000_BBBB_0000 + 64'(k));
      chk("R5", "tx bypass rev", o1_txp, rev64(64'hC0FF_EE00_1234_0000 + 64'(k)));
    end
    tx_en = 1'b1; rx_en = 1'b1;
    put(64'h0F0F_0F0F_F0F0_F0F0, 2'b10, 64'h3C3C_C3C3_3C3C_C3C3, 2'b10); cyc(); check_all();
    chk("R5", "tx resumes from held history", o0_txp, e_tx0p);
  endtask

  task automatic t_hdr();
    for (int k = 0; k < 4; k++) begin
      put(64'h1111_2222_3333_4444, 2'(k), 64'h9999_8888_7777_6666, 2'(k));
      rx1_h = 2'(k);
      cyc();
      chk("R4", "tx hdr value", {62'b0, o0_txh}, 64'(k));
      chk("R8", "tx hdr swap", {62'b0, o1_txh}, {62'b0, 1'(k), 1'(k >> 1)});
      check_all();
    end
  endtask

  task automatic t_chain();
    logic [63:0] w, prev;
    logic [1:0]  hw, hprev;
    prev = '0; hprev = '0;
    for (int k = 0; k < 8; k++) begin
      w  = 64'h0123_4567_89AB_CDEF ^ (64'(k) * 64'h1111_1111_1111_1111);
      hw = (k % 3 == 0) ? 2'b01 : 2'b10;
      tx_v = 1'b1; rx_v = 1'b1;
      tx_p = w; tx_h = hw;
      rx0_p = o0_txp; rx0_h = o0_txh;
      rx1_p = o1_txp; rx1_h = o1_txh;
      cyc();
      if (k >= 2) begin
        chk("R9", "chain payload", o0_rxp, prev);
        chk("R9", "chain payload rev", o1_rxp, prev);
        chk("R9", "chain hdr", {62'b0, o0_rxh}, {62'b0, hprev});
        chk("R9", "chain hdr rev", {62'b0, o1_rxh}, {62'b0, hprev});
      end
      check_all();
      prev = w; hprev = hw;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_v = 1'b0; rx_v = 1'b0; tx_en = 1'b1; rx_en = 1'b1;
    tx_p = '0; rx0_p = '0; rx1_p = '0; tx_h = '0; rx0_h = '0; rx1_h = '0;
    m_tx = '0; m_rx0 = '0; m_rx1 = '0;
    e_txv = 1'b0; e_rxv = 1'b0;
    e_tx0p = '0; e_tx1p = '0; e_rx0p = '0; e_rx1p = '0;
    e_tx0h = '0; e_tx1h = '0; e_rx0h = '0; e_rx1h = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_patterns();
    t_idle();
    t_bypass();
    t_hdr();
    t_chain();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule